// File: doc/BRIEF.md
# Timer Host Register Interface

This block is the processor-facing side of a three-channel interval timer. A host reaches it over an 8-bit data bus with active-low chip select, read and write strobes and a 2-bit address. Three addresses reach the channels' count registers; the fourth reaches a shared control register. A control write either reconfigures one channel (access format, counting mode, binary/decimal flag) or issues a snapshot command that freezes that channel's running count so the host can read it without tearing. The counting logic of the channels sits outside this block. They receive from it a one-cycle load strobe with a 16-bit initial value, plus their mode and decimal flag. They return their live counts.

The 16-bit counts cross the 8-bit bus in one of three formats: low byte only, high byte only, or low byte followed by high byte. Each channel has its own byte pointers for the two-byte format. A snapshot stays in place until the host has read it in full, independently for each channel.

The host bus has no back-pressure: every strobe is taken in the cycle it arrives. The strobes are sampled on the block clock, so each low phase must span at least one clock edge and each high phase between accesses must span at least one more.

Top module: `tmr_host_if`

## Requirements
- R1: Address 3 writes the control register, whose bits [7:6] pick the channel (value 3 means no channel: no effect), bits [5:4] the access field (00 snapshot, 01 low byte only, 10 high byte only, 11 low then high), bits [3:1] the mode and bit 0 the decimal flag. A configuring write updates that channel's `mode_o` slice (`mode_o[3*i+:3]`) and `bcd_o[i]` on the next clock edge.
- R2: A write is taken once per falling edge of `wr_n` seen with `cs_n` low, however long `wr_n` stays low. With `cs_n` high, a write has no effect. A single write raises at most one load strobe, for exactly one cycle.
- R3: In low-only format a count write loads `{8'h00, din}`. A read returns the low byte of the count.
- R4: In high-only format a count write loads `{din, 8'h00}`. A read returns the high byte of the count.
- R5: In low-then-high format the first count write only stores its byte. The second write loads `{second, first}`. Successive reads return the low byte and then the high byte.
- R6: A configuring control write resets both byte pointers of its channel and drops any snapshot held there.
- R7: A snapshot command copies the channel's live count, and reads return the copy while the live count moves on.
- R8: A snapshot is released only when the host has read it in full: one read in a single-byte format, two reads in low-then-high format. Snapshots on other channels remain held.
- R9: A snapshot command to a channel whose snapshot is still held is ignored.
- R10: `dout_en` is high, and `dout` carries data, only while `cs_n` and `rd_n` are both low. Otherwise `dout` is zero. A read of address 3 returns zero.
- R11: After reset every channel is in low-only format with mode 0 and the decimal flag clear, no snapshot is held, and no load strobe is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0 to 2 channel counts, 3 control |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host, zero when not reading |
| dout_en | output | 1 | High while read data is being driven |
| cnt_i | input | 48 | Live count of each channel, channel i in bits [16*i+:16] |
| ld_stb_o | output | 3 | One-cycle load strobe per channel |
| ld_val_o | output | 48 | Initial count per channel, valid with its strobe |
| mode_o | output | 9 | Counting mode per channel, 3 bits each |
| bcd_o | output | 3 | Decimal counting flag per channel |

## Verification
The assertions take for granted that the host never has `rd_n` and `wr_n` low together under chip select. They also assume each strobe's low and high phases span at least one clock edge. Without these, a write edge and a read completion could fall in the same cycle. The bench drives every access through one task at a time: it asserts a single strobe on a falling clock edge, releases it one cycle later, and leaves a quiet cycle before the next access. The live counts change only between accesses.

// File: rtl/tmr_if_pkg.sv
package tmr_if_pkg;

  // access field of a control word; 00 is the snapshot command
  typedef enum logic [1:0] {
    ACC_SNAP = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } chan_cfg_t;

  localparam int MODE_W = 3;

endpackage

// File: rtl/tmr_bus_sync.sv
module tmr_bus_sync #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_ev,
  output logic              rd_done,
  output logic [ADDR_W-1:0] rd_addr_q
);

  logic wr_q;
  logic rd_q;
  logic rd_act;

  assign rd_act  = !cs_n && !rd_n;
  assign wr_ev   = wr_q && !wr_n && !cs_n;
  assign rd_done = rd_q && !rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b1;
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_act;
      if (rd_act) rd_addr_q <= addr;
    end
  end

  AST_WR_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> !wr_ev); // R2
  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ev && rd_done)); // R2

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_if_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_ev,
  input  chan_cfg_t         cw_cfg,
  input  logic              snap_ev,
  input  logic              wr_ev,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              ld_stb,
  output logic [CNT_W-1:0]  ld_val,
  output logic [DATA_W-1:0] rd_byte,
  output logic [MODE_W-1:0] mode_o,
  output logic              bcd_o
);

  chan_cfg_t         cfg;
  logic              wptr;
  logic              rptr;
  logic              held;
  logic [CNT_W-1:0]  snap_val;
  logic [DATA_W-1:0] lo_hold;
  logic [CNT_W-1:0]  rd_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '{acc: ACC_LO, mode: '0, bcd: 1'b0};
      wptr     <= 1'b0;
      rptr     <= 1'b0;
      held     <= 1'b0;
      snap_val <= '0;
      lo_hold  <= '0;
      ld_stb   <= 1'b0;
      ld_val   <= '0;
    end else begin
      ld_stb <= 1'b0;
      if (cw_ev) begin
        cfg  <= cw_cfg;
        wptr <= 1'b0;
        rptr <= 1'b0;
        held <= 1'b0;
      end else begin
        if (snap_ev && !held) begin
          held     <= 1'b1;
          snap_val <= cnt_i;
        end
        if (wr_ev) begin
          unique case (cfg.acc)
            ACC_HI: begin
              ld_stb <= 1'b1;
              ld_val <= {din, {DATA_W{1'b0}}};
            end
            ACC_LOHI: begin
              if (!wptr) begin
                lo_hold <= din;
                wptr    <= 1'b1;
              end else begin
                ld_stb <= 1'b1;
                ld_val <= {din, lo_hold};
                wptr   <= 1'b0;
              end
            end
            default: begin
              ld_stb <= 1'b1;
              ld_val <= {{DATA_W{1'b0}}, din};
            end
          endcase
        end
        if (rd_done) begin
          if (cfg.acc == ACC_LOHI && !rptr) begin
            rptr <= 1'b1;
          end else begin
            rptr <= 1'b0;
            held <= 1'b0;
          end
        end
      end
    end
  end

  assign rd_src = held ? snap_val : cnt_i;

  always_comb begin
    if (cfg.acc == ACC_HI || (cfg.acc == ACC_LOHI && rptr))
      rd_byte = rd_src[CNT_W-1 -: DATA_W];
    else
      rd_byte = rd_src[DATA_W-1:0];
  end

  assign mode_o = cfg.mode;
  assign bcd_o  = cfg.bcd;

  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.acc != ACC_LOHI) |-> (!wptr && !rptr)); // R5
  AST_CW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cw_ev |=> (!held && !wptr && !rptr)); // R6
  AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cw_ev && !rd_done) |=> (held && $stable(snap_val))); // R9
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> !ld_stb); // R2

endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic [NUM_CH*DATA_W-1:0] bytes_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     en_i,
  output logic [DATA_W-1:0]        dout_o
);

  always_comb begin
    dout_o = '0;
    if (en_i) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr_i == ADDR_W'(i)) dout_o = bytes_i[i*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_if_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  localparam int CNT_W  = 2 * DATA_W,
  localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     rd_n,
  input  logic                     wr_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        din,
  output logic [DATA_W-1:0]        dout,
  output logic                     dout_en,
  input  logic [NUM_CH*CNT_W-1:0]  cnt_i,
  output logic [NUM_CH-1:0]        ld_stb_o,
  output logic [NUM_CH*CNT_W-1:0]  ld_val_o,
  output logic [NUM_CH*MODE_W-1:0] mode_o,
  output logic [NUM_CH-1:0]        bcd_o
);

  localparam logic [ADDR_W-1:0] CW_ADDR = '1;

  logic                     wr_ev;
  logic                     rd_done;
  logic [ADDR_W-1:0]        rd_addr_q;
  logic                     cw_hit;
  logic [ADDR_W-1:0]        cw_sel;
  chan_cfg_t                cw_cfg;
  logic [NUM_CH*DATA_W-1:0] rd_bytes;

  tmr_bus_sync #(.ADDR_W(ADDR_W)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .addr      (addr),
    .wr_ev     (wr_ev),
    .rd_done   (rd_done),
    .rd_addr_q (rd_addr_q)
  );

  assign cw_hit = wr_ev && (addr == CW_ADDR);
  assign cw_sel = din[DATA_W-1 -: ADDR_W];
  assign cw_cfg = '{acc: acc_e'(din[5:4]), mode: din[3:1], bcd: din[0]};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    logic ch_cw;
    logic ch_snap;
    logic ch_wr;
    logic ch_rd;

    assign sel     = cw_hit && (cw_sel == ADDR_W'(g));
    assign ch_cw   = sel && (cw_cfg.acc != ACC_SNAP);
    assign ch_snap = sel && (cw_cfg.acc == ACC_SNAP);
    assign ch_wr   = wr_ev && (addr == ADDR_W'(g));
    assign ch_rd   = rd_done && (rd_addr_q == ADDR_W'(g));

    tmr_chan_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .cw_ev   (ch_cw),
      .cw_cfg  (cw_cfg),
      .snap_ev (ch_snap),
      .wr_ev   (ch_wr),
      .rd_done (ch_rd),
      .din     (din),
      .cnt_i   (cnt_i[g*CNT_W +: CNT_W]),
      .ld_stb  (ld_stb_o[g]),
      .ld_val  (ld_val_o[g*CNT_W +: CNT_W]),
      .rd_byte (rd_bytes[g*DATA_W +: DATA_W]),
      .mode_o  (mode_o[g*MODE_W +: MODE_W]),
      .bcd_o   (bcd_o[g])
    );
  end

  assign dout_en = !cs_n && !rd_n;

  tmr_rd_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
    .bytes_i (rd_bytes),
    .addr_i  (addr),
    .en_i    (dout_en),
    .dout_o  (dout)
  );

  AST_ONE_CHANNEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_stb_o)); // R2
  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ev |=> $stable(mode_o) && $stable(bcd_o)); // R1

endmodule

// File: tb/test_tmr_host_if.sv
module test_tmr_host_if;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;

  localparam logic [2:0] OP_WR  = 3'd0;
  localparam logic [2:0] OP_RD  = 3'd1;
  localparam logic [2:0] OP_CNT = 3'd2;
  localparam logic [2:0] OP_LD  = 3'd3;
  localparam logic [2:0] OP_CFG = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  ch;
    logic [15:0] arg;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 55;
  localparam vec_t VEC [NV] = '{
    '{OP_WR,  2'd3, 16'h0014, 16'h0000, 8'd1},  // R1 ch0 low-only mode 2
    '{OP_CFG, 2'd0, 16'h0000, 16'h0002, 8'd1},
    '{OP_WR,  2'd0, 16'h005A, 16'h0000, 8'd3},  // R3
    '{OP_LD,  2'd0, 16'd1,    16'h005A, 8'd3},
    '{OP_CNT, 2'd0, 16'h1234, 16'h0000, 8'd3},
    '{OP_RD,  2'd0, 16'h0000, 16'h0034, 8'd3},
    '{OP_WR,  2'd3, 16'h0063, 16'h0000, 8'd1},  // ch1 high-only mode 1 decimal
    '{OP_CFG, 2'd1, 16'h0000, 16'h0009, 8'd1},
    '{OP_WR,  2'd1, 16'h00AB, 16'h0000, 8'd4},  // R4
    '{OP_LD,  2'd1, 16'd1,    16'hAB00, 8'd4},
    '{OP_CNT, 2'd1, 16'hBEEF, 16'h0000, 8'd4},
    '{OP_RD,  2'd1, 16'h0000, 16'h00BE, 8'd4},
    '{OP_WR,  2'd3, 16'h00B6, 16'h0000, 8'd5},  // R5 ch2 low-then-high mode 3
    '{OP_WR,  2'd2, 16'h0034, 16'h0000, 8'd5},
    '{OP_LD,  2'd2, 16'd0,    16'h0000, 8'd5},
    '{OP_WR,  2'd2, 16'h0012, 16'h0000, 8'd5},
    '{OP_LD,  2'd2, 16'd1,    16'h1234, 8'd5},
    '{OP_CNT, 2'd2, 16'hA55A, 16'h0000, 8'd5},
    '{OP_RD,  2'd2, 16'h0000, 16'h005A, 8'd5},
    '{OP_RD,  2'd2, 16'h0000, 16'h00A5, 8'd5},
    '{OP_WR,  2'd3, 16'h0080, 16'h0000, 8'd7},  // R7 snapshot ch2
    '{OP_CNT, 2'd2, 16'h0F0F, 16'h0000, 8'd7},
    '{OP_RD,  2'd2, 16'h0000, 16'h005A, 8'd7},
    '{OP_WR,  2'd3, 16'h0080, 16'h0000, 8'd9},  // R9 second snapshot ignored
    '{OP_CNT, 2'd2, 16'h1111, 16'h0000, 8'd9},
    '{OP_RD,  2'd2, 16'h0000, 16'h00A5, 8'd9},
    '{OP_RD,  2'd2, 16'h0000, 16'h0011, 8'd8},  // R8 released after two reads
    '{OP_RD,  2'd2, 16'h0000, 16'h0011, 8'd8},
    '{OP_CNT, 2'd0, 16'h2222, 16'h0000, 8'd8},
    '{OP_CNT, 2'd1, 16'h3333, 16'h0000, 8'd8},
    '{OP_WR,  2'd3, 16'h0000, 16'h0000, 8'd7},  // snapshot ch0
    '{OP_WR,  2'd3, 16'h0040, 16'h0000, 8'd7},  // snapshot ch1
    '{OP_CNT, 2'd0, 16'h4444, 16'h0000, 8'd8},
    '{OP_CNT, 2'd1, 16'h5555, 16'h0000, 8'd8},
    '{OP_RD,  2'd0, 16'h0000, 16'h0022, 8'd7},
    '{OP_RD,  2'd0, 16'h0000, 16'h0044, 8'd8},  // R8 one read releases low-only
    '{OP_RD,  2'd1, 16'h0000, 16'h0033, 8'd8},  // ch1 still held
    '{OP_RD,  2'd1, 16'h0000, 16'h0055, 8'd8},
    '{OP_WR,  2'd3, 16'h0080, 16'h0000, 8'd6},  // R6 snapshot then reprogram
    '{OP_RD,  2'd2, 16'h0000, 16'h0011, 8'd6},
    '{OP_CNT, 2'd2, 16'h7788, 16'h0000, 8'd6},
    '{OP_WR,  2'd3, 16'h00B4, 16'h0000, 8'd6},
    '{OP_RD,  2'd2, 16'h0000, 16'h0088, 8'd6},
    '{OP_RD,  2'd2, 16'h0000, 16'h0077, 8'd6},
    '{OP_CFG, 2'd2, 16'h0000, 16'h0002, 8'd1},
    '{OP_WR,  2'd2, 16'h0001, 16'h0000, 8'd6},  // half write, then reprogram
    '{OP_WR,  2'd3, 16'h00B4, 16'h0000, 8'd6},
    '{OP_WR,  2'd2, 16'h0002, 16'h0000, 8'd6},
    '{OP_WR,  2'd2, 16'h0003, 16'h0000, 8'd6},
    '{OP_LD,  2'd2, 16'd2,    16'h0302, 8'd6},
    '{OP_RD,  2'd3, 16'h0000, 16'h0000, 8'd10}, // R10 control address reads zero
    '{OP_WR,  2'd3, 16'h00D6, 16'h0000, 8'd1},  // R1 select 3 has no effect
    '{OP_CFG, 2'd0, 16'h0000, 16'h0002, 8'd1},
    '{OP_CFG, 2'd1, 16'h0000, 16'h0009, 8'd1},
    '{OP_CFG, 2'd2, 16'h0000, 16'h0002, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;
  logic [47:0] cnt_drv = '0;
  logic [2:0]  ld_stb;
  logic [47:0] ld_val;
  logic [8:0]  mode;
  logic [2:0]  bcd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int          ld_cnt  [NCH];
  logic [15:0] last_ld [NCH];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tmr_host_if i_tmr_host_if (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .din      (din),
    .dout     (dout),
    .dout_en  (dout_en),
    .cnt_i    (cnt_drv),
    .ld_stb_o (ld_stb),
    .ld_val_o (ld_val),
    .mode_o   (mode),
    .bcd_o    (bcd)
  );

  initial begin
    for (int c = 0; c < NCH; c++) begin
      ld_cnt[c]  = 0;
      last_ld[c] = '0;
    end
  end

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (ld_stb[c]) begin
        ld_cnt[c]++;
        last_ld[c] = ld_val[c*16 +: 16];
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic en);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #1;
    d = dout; en = dout_en;
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    logic       ren;
    int         n0;

    // reset state, R11
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 modes", {7'd0, mode}, 16'h0000);
    check("R11 bcd", {13'd0, bcd}, 16'h0000);
    check("R11 strobes", {13'd0, ld_stb}, 16'h0000);
    check("R10 idle dout_en", {15'd0, dout_en}, 16'h0000);
    cnt_drv[15:0] = 16'hCDAB;
    bus_read(2'd0, rb, ren);
    check("R11 low-only default", {8'd0, rb}, 16'h00AB);
    check("R10 dout_en in read", {15'd0, ren}, 16'h0001);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VEC[v].req, v);
      case (VEC[v].op)
        OP_WR:  bus_write(VEC[v].ch, VEC[v].arg[7:0]);
        OP_CNT: begin
          @(negedge clk);
          cnt_drv[VEC[v].ch*16 +: 16] = VEC[v].arg;
        end
        OP_RD: begin
          bus_read(VEC[v].ch, rb, ren);
          check(tag, {8'd0, rb}, VEC[v].exp);
        end
        OP_LD: begin
          check(tag, 16'(ld_cnt[VEC[v].ch]), VEC[v].arg);
          check(tag, last_ld[VEC[v].ch], VEC[v].exp);
        end
        default: begin
          check(tag, {12'd0, bcd[VEC[v].ch], mode[VEC[v].ch*3 +: 3]}, VEC[v].exp);
        end
      endcase
    end

    // R2: write with chip select high is ignored
    n0 = ld_cnt[0];
    @(negedge clk);
    addr = 2'd0; din = 8'h77; cs_n = 1'b1; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    check("R2 cs high count", 16'(ld_cnt[0]), 16'(n0));
    check("R2 cs high value", last_ld[0], 16'h005A);

    // R2: write held low for several cycles loads once
    @(negedge clk);
    addr = 2'd0; din = 8'h66; cs_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    check("R2 held write count", 16'(ld_cnt[0]), 16'(n0 + 1));
    check("R2 held write value", last_ld[0], 16'h0066);

    // R10: no read data without both strobes
    @(negedge clk);
    addr = 2'd0; cs_n = 1'b0; rd_n = 1'b1;
    #1;
    check("R10 rd high en", {15'd0, dout_en}, 16'h0000);
    check("R10 rd high data", {8'd0, dout}, 16'h0000);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b0;
    #1;
    check("R10 cs high en", {15'd0, dout_en}, 16'h0000);
    check("R10 cs high data", {8'd0, dout}, 16'h0000);
    @(negedge clk);
    rd_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule